// File: doc/BRIEF.md
# Numeric Coprocessor Interface Controller

This block sits between a processor's bus request port and its external bus. It passes numeric instructions and operands to an attached floating-point coprocessor. Coprocessor traffic runs as IO-type bus cycles to a reserved region above the ordinary 64 KB IO space. A request belongs to the coprocessor when the top address bit is 1 and the memory/IO indicator is 0. Every other request goes straight through as a single full-width beat, one clock after it is accepted.

Two kinds of coprocessor can be attached. The wide kind takes 32-bit quantities. The narrow kind takes 16-bit quantities, so each 32-bit operand is split into two IO cycles: the low half first at the request address, then the high half at that address plus two. While reset is held, the block samples a dedicated input that tells it whether the wide kind is fitted, and it keeps that answer until the next reset.

The coprocessor drives an asynchronous BUSY line while it executes. That line is synchronized to the block clock. A request that starts a new numeric instruction is held off while the synchronized BUSY reads high, and it issues on the first clock after it reads low. Operand transfers that follow an instruction do not wait on BUSY, and neither does ordinary traffic.

Top module: `copro_if_ctrl`

## Requirements
- R1: While `rst_n` is low, `wide_mode` follows `wide_fitted` on every clock edge. After reset is released, `wide_mode` holds the last value sampled and ignores later changes of `wide_fitted`.
- R2: A request is a coprocessor cycle only when `req_addr[31]` is 1 and `req_mio` is 0 (0 means IO, 1 means memory). A memory request with `req_addr[31]` set is treated as ordinary traffic.
- R3: When `wide_mode` is 1, an accepted coprocessor request produces exactly one beat on the clock after acceptance. That beat has `bus_wide`=1, `bus_upper`=0, and the request's address, data and `bus_mio`=0.
- R4: When `wide_mode` is 0, an accepted coprocessor request produces two beats on consecutive clocks, both with `bus_wide`=0. The first beat has `bus_upper`=0, the request address, and `bus_data` = {16'h0, data[15:0]}. The second beat has `bus_upper`=1, address + 2, and `bus_data` = {16'h0, data[31:16]}.
- R5: BUSY passes through a synchronizer of `SYNC_STAGES` (default 2) flops. A coprocessor request with `req_first`=1 is not accepted (`req_ready`=0) while the synchronized BUSY is 1, and it is accepted on the first clock after the synchronized BUSY reads 0.
- R6: A coprocessor request with `req_first`=0 (operand transfer) is not stalled by BUSY.
- R7: An ordinary request is accepted whatever the state of BUSY. It appears on the bus one clock after acceptance as a single beat with unchanged address, data and `bus_mio`, with `bus_wide`=1 and `bus_upper`=0.
- R8: While the high-half beat of a narrow transfer is pending, `req_ready` is 0.
- R9: While reset is held and after it is released, with no request presented, `bus_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_fitted | input | 1 | 1 if the 32-bit coprocessor is present; sampled during reset |
| copro_busy | input | 1 | Asynchronous BUSY from the coprocessor |
| req_valid | input | 1 | Processor request present |
| req_addr | input | ADDR_W | Request address |
| req_mio | input | 1 | 1 memory, 0 IO |
| req_first | input | 1 | Request starts a new numeric instruction |
| req_data | input | DATA_W | Request write data |
| req_ready | output | 1 | Request accepted on this clock when high with req_valid |
| bus_valid | output | 1 | A bus beat is presented |
| bus_addr | output | ADDR_W | Beat address |
| bus_mio | output | 1 | Beat memory/IO indicator |
| bus_data | output | DATA_W | Beat data |
| bus_wide | output | 1 | 1 full-width beat, 0 half-width beat |
| bus_upper | output | 1 | Beat carries the high half of a split operand |
| wide_mode | output | 1 | Latched presence flag |

## Verification
Some properties are checked on every cycle. The presence flag must stay stable outside reset. A low-half beat must be followed at once by its high half at address plus two. The width of each coprocessor beat must match the presence flag. Ordinary traffic must pass through in one clock with its fields intact. `req_ready` must stay low when BUSY has been high for longer than the synchronizer delay, and it must never be low for ordinary traffic except behind a pending high half. The exact clock on which a stalled instruction issues after BUSY falls, the reset-time sampling of the presence pin, and the behaviour across a second reset with the other coprocessor type are shown only by the bench's scenarios, compared against its reference model.

// File: rtl/copro_pkg.sv
package copro_pkg;
   typedef enum logic {
      PH_IDLE  = 1'b0,
      PH_UPPER = 1'b1
   } phase_e;

   function automatic logic is_copro_cycle(input logic top_bit, input logic mio);
      return top_bit & ~mio;
   endfunction
endpackage

// File: rtl/copro_busy_sync.sv
module copro_busy_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_async,
   output logic busy_sync
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[0], busy_async};
         end
      end else begin : g_long
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], busy_async};
         end
      end
   endgenerate

   assign busy_sync = chain_q[STAGES-1];
endmodule

// File: rtl/copro_presence.sv
module copro_presence (
   input  logic clk,
   input  logic rst_n,
   input  logic fitted_pin,
   output logic wide_flag
);
   always_ff @(posedge clk) begin
      if (!rst_n) wide_flag <= fitted_pin;
   end
endmodule

// File: rtl/copro_xfer_fsm.sv
module copro_xfer_fsm
   import copro_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int NARROW_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide_flag,
   input  logic              busy_sync,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_mio,
   input  logic              req_first,
   input  logic [DATA_W-1:0] req_data,
   output logic              req_ready,
   output logic              bus_valid,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_mio,
   output logic [DATA_W-1:0] bus_data,
   output logic              bus_wide,
   output logic              bus_upper
);
   localparam int HALF_BYTES = NARROW_W / 8;
   localparam int PAD_W      = DATA_W - NARROW_W;

   phase_e              phase_q;
   logic [NARROW_W-1:0] hold_hi_q;
   logic [ADDR_W-1:0]   hold_addr_q;
   logic                copro_hit;
   logic                split;
   logic                take;

   assign copro_hit = is_copro_cycle(req_addr[ADDR_W-1], req_mio);
   assign split     = copro_hit & ~wide_flag;
   assign req_ready = (phase_q == PH_IDLE) & ~(copro_hit & req_first & busy_sync);
   assign take      = req_valid & req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         hold_hi_q   <= '0;
         hold_addr_q <= '0;
         bus_valid   <= 1'b0;
         bus_addr    <= '0;
         bus_mio     <= 1'b0;
         bus_data    <= '0;
         bus_wide    <= 1'b0;
         bus_upper   <= 1'b0;
      end else begin
         case (phase_q)
            PH_IDLE: begin
               bus_valid <= take;
               bus_upper <= 1'b0;
               if (take) begin
                  bus_addr <= req_addr;
                  bus_mio  <= req_mio;
                  bus_wide <= ~split;
                  if (split) begin
                     bus_data    <= {{PAD_W{1'b0}}, req_data[NARROW_W-1:0]};
                     hold_hi_q   <= req_data[DATA_W-1:NARROW_W];
                     hold_addr_q <= req_addr + ADDR_W'(HALF_BYTES);
                     phase_q     <= PH_UPPER;
                  end else begin
                     bus_data <= req_data;
                  end
               end
            end
            default: begin
               bus_valid <= 1'b1;
               bus_addr  <= hold_addr_q;
               bus_data  <= {{PAD_W{1'b0}}, hold_hi_q};
               bus_wide  <= 1'b0;
               bus_upper <= 1'b1;
               phase_q   <= PH_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/copro_if_ctrl.sv
module copro_if_ctrl #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int NARROW_W    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide_fitted,
   input  logic              copro_busy,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_mio,
   input  logic              req_first,
   input  logic [DATA_W-1:0] req_data,
   output logic              req_ready,
   output logic              bus_valid,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_mio,
   output logic [DATA_W-1:0] bus_data,
   output logic              bus_wide,
   output logic              bus_upper,
   output logic              wide_mode
);
   generate
      if (DATA_W != 2 * NARROW_W) begin : g_bad_width
         $error("DATA_W must be twice NARROW_W");
      end
      if (NARROW_W % 8 != 0) begin : g_bad_narrow
         $error("NARROW_W must be a whole number of bytes");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ADDR_W < 17) begin : g_bad_addr
         $error("ADDR_W must reach above the 64 KB IO space");
      end
   endgenerate

   logic busy_s;

   copro_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy_async (copro_busy),
      .busy_sync  (busy_s)
   );

   copro_presence u_pres (
      .clk        (clk),
      .rst_n      (rst_n),
      .fitted_pin (wide_fitted),
      .wide_flag  (wide_mode)
   );

   copro_xfer_fsm #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .NARROW_W (NARROW_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wide_flag (wide_mode),
      .busy_sync (busy_s),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_mio   (req_mio),
      .req_first (req_first),
      .req_data  (req_data),
      .req_ready (req_ready),
      .bus_valid (bus_valid),
      .bus_addr  (bus_addr),
      .bus_mio   (bus_mio),
      .bus_data  (bus_data),
      .bus_wide  (bus_wide),
      .bus_upper (bus_upper)
   );
endmodule

// File: rtl/copro_if_chk.sv
module copro_if_chk #(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int NARROW_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              copro_busy,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_mio,
   input logic              req_first,
   input logic [DATA_W-1:0] req_data,
   input logic              req_ready,
   input logic              bus_valid,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_mio,
   input logic [DATA_W-1:0] bus_data,
   input logic              bus_wide,
   input logic              bus_upper,
   input logic              wide_mode
);
   localparam int HALF_BYTES = NARROW_W / 8;

   logic req_copro;
   logic low_half_out;
   assign req_copro    = req_addr[ADDR_W-1] & ~req_mio;
   assign low_half_out = bus_valid & ~bus_wide & ~bus_upper;

   // R1
   presence_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(wide_mode));

   // R4
   upper_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      low_half_out |=> (bus_valid && bus_upper && !bus_wide &&
                        bus_addr == $past(bus_addr) + ADDR_W'(HALF_BYTES)));

   // R3
   copro_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_addr[ADDR_W-1] && !bus_mio && !bus_upper) |-> (bus_wide == wide_mode));

   // R5
   busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n, 2) && $past(copro_busy, 2) && req_valid && req_first && req_copro)
      |-> !req_ready);

   // R7
   passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_copro)
      |=> (bus_valid && bus_wide && !bus_upper && bus_addr == $past(req_addr) &&
           bus_data == $past(req_data) && bus_mio == $past(req_mio)));

   // R7
   ordinary_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_copro && !low_half_out) |-> req_ready);

   // R8
   upper_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      low_half_out |-> !req_ready);
endmodule

bind copro_if_ctrl copro_if_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .NARROW_W (NARROW_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .copro_busy (copro_busy),
   .req_valid  (req_valid),
   .req_addr   (req_addr),
   .req_mio    (req_mio),
   .req_first  (req_first),
   .req_data   (req_data),
   .req_ready  (req_ready),
   .bus_valid  (bus_valid),
   .bus_addr   (bus_addr),
   .bus_mio    (bus_mio),
   .bus_data   (bus_data),
   .bus_wide   (bus_wide),
   .bus_upper  (bus_upper),
   .wide_mode  (wide_mode)
);

// File: tb/tb_copro_if_ctrl.sv
`timescale 1ns/1ps
module tb_copro_if_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide_fitted = 1'b0;
   logic        copro_busy = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_mio = 1'b0;
   logic        req_first = 1'b0;
   logic [31:0] req_data = '0;
   logic        req_ready;
   logic        bus_valid;
   logic [31:0] bus_addr;
   logic        bus_mio;
   logic [31:0] bus_data;
   logic        bus_wide;
   logic        bus_upper;
   logic        wide_mode;

   always #4 clk = ~clk;

   copro_if_ctrl dut (
      .clk(clk), .rst_n(rst_n), .wide_fitted(wide_fitted), .copro_busy(copro_busy),
      .req_valid(req_valid), .req_addr(req_addr), .req_mio(req_mio),
      .req_first(req_first), .req_data(req_data), .req_ready(req_ready),
      .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_mio(bus_mio),
      .bus_data(bus_data), .bus_wide(bus_wide), .bus_upper(bus_upper),
      .wide_mode(wide_mode)
   );

   typedef struct {
      logic [31:0] addr;
      logic [31:0] data;
      logic        mio;
      logic        wide;
      logic        upper;
      string       tag;
   } beat_t;

   int    n_checks = 0;
   int    n_fail = 0;
   int    edges = 0;
   beat_t pend_q[$];
   beat_t cur;
   logic  cur_valid = 1'b0;
   logic  m_wide = 1'b0;
   logic  b1 = 1'b0;
   logic  b2 = 1'b0;
   bit    done = 1'b0;

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // reference model, advanced on every clock edge
   always @(posedge clk) begin
      edges++;
      if (!rst_n) begin
         m_wide    = wide_fitted;
         b1        = 1'b0;
         b2        = 1'b0;
         cur_valid = 1'b0;
         pend_q.delete();
      end else begin
         logic cop;
         logic rdy;
         cop = req_addr[31] && !req_mio;
         rdy = (pend_q.size() == 0) && !(cop && req_first && b2);
         if (pend_q.size() != 0) begin
            cur       = pend_q.pop_front();
            cur_valid = 1'b1;
         end else if (req_valid && rdy) begin
            cur_valid = 1'b1;
            cur.addr  = req_addr;
            cur.mio   = req_mio;
            cur.upper = 1'b0;
            if (cop && !m_wide) begin
               beat_t hi;
               cur.data  = {16'h0, req_data[15:0]};
               cur.wide  = 1'b0;
               cur.tag   = "R4";
               hi.addr   = req_addr + 32'd2;
               hi.data   = {16'h0, req_data[31:16]};
               hi.mio    = req_mio;
               hi.wide   = 1'b0;
               hi.upper  = 1'b1;
               hi.tag    = "R4";
               pend_q.push_back(hi);
            end else begin
               cur.data = req_data;
               cur.wide = 1'b1;
               cur.tag  = cop ? "R3" : (req_addr[31] ? "R2" : "R7");
            end
         end else begin
            cur_valid = 1'b0;
         end
         b2 = b1;
         b1 = copro_busy;
      end
   end

   // comparison on every clock, away from the active edge
   always @(negedge clk) begin
      if (edges > 0 && !done) begin
         logic  cop;
         logic  e_rdy;
         string rtag;
         cop = req_addr[31] && !req_mio;
         check("R1", "wide_mode", {31'b0, wide_mode}, {31'b0, m_wide});
         if (!rst_n) begin
            check("R9", "bus_valid in reset", {31'b0, bus_valid}, 32'd0);
         end else begin
            e_rdy = (pend_q.size() == 0) && !(cop && req_first && b2);
            if (pend_q.size() != 0) rtag = "R8";
            else if (!req_valid)    rtag = "R9";
            else if (cop && req_first) rtag = "R5";
            else if (cop)           rtag = "R6";
            else                    rtag = "R7";
            check(rtag, "req_ready", {31'b0, req_ready}, {31'b0, e_rdy});
            check(cur_valid ? cur.tag : "R5", "bus_valid", {31'b0, bus_valid}, {31'b0, cur_valid});
            if (cur_valid && bus_valid) begin
               check(cur.tag, "bus_addr", bus_addr, cur.addr);
               check(cur.tag, "bus_data", bus_data, cur.data);
               check(cur.tag, "bus_mio", {31'b0, bus_mio}, {31'b0, cur.mio});
               check(cur.tag, "bus_wide", {31'b0, bus_wide}, {31'b0, cur.wide});
               check(cur.tag, "bus_upper", {31'b0, bus_upper}, {31'b0, cur.upper});
            end
         end
      end
   end

   task automatic issue(input logic [31:0] a, input logic m, input logic f, input logic [31:0] d);
      logic r;
      req_valid = 1'b1;
      req_addr  = a;
      req_mio   = m;
      req_first = f;
      req_data  = d;
      forever begin
         @(negedge clk);
         r = req_ready;
         @(posedge clk);
         #1;
         if (r) break;
      end
      req_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_reset(input logic fitted);
      rst_n       = 1'b0;
      wide_fitted = fitted;
      idle(3);
      rst_n = 1'b1;
      #1;
      wide_fitted = ~fitted;   // R1: change after release must be ignored
   endtask

   task automatic finish_run;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL R5 watchdog: actual=hung expected=complete");
      finish_run();
   end

   initial begin
      // narrow coprocessor fitted (R9 reset state, R1 sampling)
      do_reset(1'b0);
      idle(3);
      issue(32'h0000_00F0, 1'b0, 1'b0, 32'hCAFE_0001);   // R7 ordinary IO
      issue(32'h8000_1000, 1'b1, 1'b0, 32'hCAFE_0002);   // R2 memory with bit 31 set
      issue(32'h8000_00F8, 1'b0, 1'b1, 32'h1234_ABCD);   // R4 split
      issue(32'h8000_00FC, 1'b0, 1'b0, 32'h5566_7788);   // R8 back to back
      issue(32'h0000_0060, 1'b0, 1'b1, 32'hCAFE_0003);   // R7
      idle(2);
      copro_busy = 1'b1;
      idle(4);
      issue(32'h8000_00FC, 1'b0, 1'b0, 32'h0BAD_F00D);   // R6 operand not stalled
      issue(32'h0000_0080, 1'b0, 1'b1, 32'hCAFE_0004);   // R7 ignores BUSY
      fork
         issue(32'h8000_00F8, 1'b0, 1'b1, 32'hDEAD_BEEF); // R5 stall
         begin idle(6); copro_busy = 1'b0; end
      join
      idle(4);
      // wide coprocessor fitted
      do_reset(1'b1);
      idle(2);
      issue(32'h8000_00F8, 1'b0, 1'b1, 32'h89AB_CDEF);   // R3 single beat
      issue(32'h8000_00FC, 1'b0, 1'b0, 32'h0102_0304);   // R3
      copro_busy = 1'b1;
      idle(3);
      fork
         issue(32'h8000_00F8, 1'b0, 1'b1, 32'h7777_1111); // R5 stall, wide
         begin idle(3); copro_busy = 1'b0; end
      join
      copro_busy = 1'b1;
      idle(1);
      copro_busy = 1'b0;
      issue(32'h8000_00F8, 1'b0, 1'b1, 32'h2222_3333);   // R5 short pulse
      issue(32'hFFFF_FFF0, 1'b1, 1'b1, 32'h4444_5555);   // R2 memory
      idle(4);
      finish_run();
   end
endmodule